// File: doc/BRIEF.md
# Vertical Blanking Pulse Timer

This block turns a digitised vertical flyback level into an active-low vertical blanking pulse for a CRT driver. A rising edge on the flyback level starts the pulse, and the pulse then lasts a number of horizontal lines set by a 7-bit duration value from the host register file. The block counts rising edges of the horizontal blanking strobe, not clock cycles, so the pulse length follows the line rate whatever the system clock is.

The synchronised flyback level is ORed into the output. Blanking therefore begins as soon as the edge has passed the synchroniser, before the first line is counted. While a pulse is running, new flyback edges cannot restart or extend it. If no flyback edge arrives for 2048 lines, the block raises a no-video flag so the video path can force black. It also keeps issuing blanking pulses of the programmed length every 2048 lines, so the driver keeps its bias. The next real flyback edge clears the flag.

Top module: `vblank_timer`

## Requirements
- R1: A pulse starts only on a rising edge of the synchronised flyback level. A falling edge never starts or restarts the line count.
- R2: With a duration D of 1 to 127, the pulse ends on the D-th rising edge of the horizontal strobe after the trigger. A strobe held high for several clocks counts once. With one strobe every L clocks and a line-aligned trigger, the output is low for D*L clocks.
- R3: A flyback edge that arrives while a pulse is active neither restarts nor lengthens the pulse.
- R4: The output goes low two clocks after the flyback input rises (the synchroniser delay). It stays low for as long as the synchronised flyback level is high, whatever the counter state.
- R5: A duration of 0 adds no counted extension. The output is then low only while the synchronised flyback level is high.
- R6: The duration value is captured at the trigger. Changing it during a pulse does not alter that pulse, and the new value applies to the next trigger.
- R7: After 2048 consecutive strobe edges with no flyback rising edge, `no_video_o` goes to 1. A pulse of the programmed duration starts at that point, and another starts every further 2048 lines while no flyback edge arrives.
- R8: The next flyback rising edge clears `no_video_o` to 0.
- R9: After reset, `vblank_n_o` is 1 and `no_video_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vflyback_i | input | 1 | Digitised vertical flyback level, asynchronous |
| hstrobe_i | input | 1 | Horizontal blanking strobe, one pulse per line, asynchronous |
| lines_i | input | 7 | Blanking duration in lines, from the host register |
| vblank_n_o | output | 1 | Vertical blanking pulse, active low |
| no_video_o | output | 1 | Flyback-lost flag, high forces video to black |

## Verification
The hardest state to reach from the ports is flyback loss. It needs 2048 strobe edges with no flyback edge, followed by a free-running pulse whose exact length must still be measured. The stimulus keeps a free-running line generator going, stops the flyback input, and samples the flag a few lines before and a few lines after the 2048-line boundary. The scoreboard expects one pulse of the programmed length with no flyback input present. The lockout case is reached by injecting a short second flyback pulse midway through an active pulse; the scoreboard still expects a single pulse of unchanged width.

// File: rtl/vbt_pkg.sv
package vbt_pkg;

    localparam int DUR_W_DEF       = 7;
    localparam int LOSS_LINES_DEF  = 2048;
    localparam int SYNC_STAGES_DEF = 2;

    // index of each asynchronous input inside the synchroniser bank
    localparam int IDX_VFLY = 0;
    localparam int IDX_HSTR = 1;
    localparam int N_ASYNC  = 2;

    typedef struct packed {
        logic level;
        logic rise;
    } sig_edge_t;

endpackage

// File: rtl/vbt_sync.sv
module vbt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '0;
                else     chain_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= chain_q[LAST];
    end

    assign level_o = chain_q[LAST];
    assign rise_o  = chain_q[LAST] & ~prev_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_chk
        AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            rise_o[b] |=> !rise_o[b]); // R1
    end

endmodule

// File: rtl/vbt_line_timer.sv
module vbt_line_timer #(
    parameter int DUR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic             line_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             active_o
);
    logic             active_q;
    logic [DUR_W-1:0] cnt_q;
    logic [DUR_W-1:0] dur_q;
    logic [DUR_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + DUR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            dur_q    <= '0;
        end else if (trig_i && !active_q) begin
            active_q <= (dur_i != '0);
            cnt_q    <= '0;
            dur_q    <= dur_i;
        end else if (active_q && line_i) begin
            if (cnt_inc == dur_q) active_q <= 1'b0;
            cnt_q <= cnt_inc;
        end
    end

    assign active_o = active_q;

    AST_START_FROM_TRIG: assert property (@(posedge clk) disable iff (rst)
        $rose(active_q) |-> $past(trig_i)); // R1
    AST_COUNT_BELOW_DUR: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (cnt_q < dur_q)); // R2
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        (active_q && trig_i && !line_i) |=> (cnt_q == $past(cnt_q))); // R3
    AST_DUR_HELD: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q)) |-> $stable(dur_q)); // R6

endmodule

// File: rtl/vbt_loss_watch.sv
module vbt_loss_watch #(
    parameter int LOSS_LINES = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic vs_rise_i,
    input  logic line_i,
    output logic timeout_o,
    output logic no_video_o
);
    localparam int CNT_W = $clog2(LOSS_LINES);
    localparam logic [CNT_W-1:0] LAST_LINE = CNT_W'(LOSS_LINES - 1);

    logic [CNT_W-1:0] lcnt_q;
    logic             lost_q;

    assign timeout_o = line_i && !vs_rise_i && (lcnt_q == LAST_LINE);

    always_ff @(posedge clk) begin
        if (rst) begin
            lcnt_q <= '0;
            lost_q <= 1'b0;
        end else if (vs_rise_i) begin
            lcnt_q <= '0;
            lost_q <= 1'b0;
        end else if (line_i) begin
            if (timeout_o) begin
                lcnt_q <= '0;
                lost_q <= 1'b1;
            end else begin
                lcnt_q <= lcnt_q + CNT_W'(1);
            end
        end
    end

    assign no_video_o = lost_q;

    AST_LOSS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> no_video_o); // R7
    AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        vs_rise_i |=> !no_video_o); // R8

endmodule

// File: rtl/vblank_timer.sv
module vblank_timer
    import vbt_pkg::*;
#(
    parameter int DUR_W       = DUR_W_DEF,
    parameter int LOSS_LINES  = LOSS_LINES_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vflyback_i,
    input  logic             hstrobe_i,
    input  logic [DUR_W-1:0] lines_i,
    output logic             vblank_n_o,
    output logic             no_video_o
);
    logic [N_ASYNC-1:0] raw;
    logic [N_ASYNC-1:0] lvl;
    logic [N_ASYNC-1:0] rse;
    sig_edge_t          vfly;
    sig_edge_t          hstr;
    logic               timeout;
    logic               active;

    always_comb begin
        raw           = '0;
        raw[IDX_VFLY] = vflyback_i;
        raw[IDX_HSTR] = hstrobe_i;
    end

    vbt_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw),
        .level_o (lvl),
        .rise_o  (rse)
    );

    assign vfly = '{level: lvl[IDX_VFLY], rise: rse[IDX_VFLY]};
    assign hstr = '{level: lvl[IDX_HSTR], rise: rse[IDX_HSTR]};

    vbt_loss_watch #(.LOSS_LINES(LOSS_LINES)) u_watch (
        .clk        (clk),
        .rst        (rst),
        .vs_rise_i  (vfly.rise),
        .line_i     (hstr.rise),
        .timeout_o  (timeout),
        .no_video_o (no_video_o)
    );

    vbt_line_timer #(.DUR_W(DUR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (vfly.rise || timeout),
        .line_i   (hstr.rise),
        .dur_i    (lines_i),
        .active_o (active)
    );

    // flyback level bypasses the counter so blanking has no dead time
    assign vblank_n_o = ~(vfly.level | active);

endmodule

// File: tb/vblank_timer_bench.sv
module vblank_timer_bench;
    localparam int L = 16;     // clocks per line
    localparam int HB = 4;     // strobe high clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vfly = 1'b0;
    logic       hstr = 1'b0;
    logic [6:0] dur = 7'd0;
    logic       vblank_n;
    logic       no_video;

    int tests = 0;
    int fails = 0;
    int phase = 0;
    bit done = 1'b0;

    typedef struct {
        int    width;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    vblank_timer u_vblank_timer (
        .clk        (clk),
        .rst        (rst),
        .vflyback_i (vfly),
        .hstrobe_i  (hstr),
        .lines_i    (dur),
        .vblank_n_o (vblank_n),
        .no_video_o (no_video)
    );

    // free-running line generator
    initial begin
        forever begin
            @(negedge clk);
            phase = (phase == L - 1) ? 0 : phase + 1;
            hstr  = (phase < HB);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: measure every low pulse and compare with the scoreboard
    int width = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (vblank_n == 1'b0) begin
                width++;
            end else if (width > 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected pulse", width, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(width == e.width, e.tag, width, e.width);
                end
                width = 0;
            end
        end
    end

    task automatic align_line();
        do @(posedge clk); while (phase != 0);
        @(negedge clk);
    endtask

    task automatic fire(input int hold, input int exp_w, input string tag);
        exp_t e;
        align_line();
        e.width = exp_w;
        e.tag   = tag;
        exp_q.push_back(e);
        vfly = 1'b1;
        repeat (hold) @(negedge clk);
        vfly = 1'b0;
    endtask

    task automatic wait_lines(input int n);
        repeat (n * L) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(vblank_n == 1'b1, "R9 vblank_n after reset", int'(vblank_n), 1);
        check(no_video == 1'b0, "R9 no_video after reset", int'(no_video), 0);

        // R2 several durations
        dur = 7'd10; fire(3, 10 * L, "R2 dur=10"); wait_lines(12);
        dur = 7'd1;  fire(3, 1 * L, "R2 dur=1");   wait_lines(3);
        dur = 7'd127; fire(3, 127 * L, "R2 dur=127"); wait_lines(129);

        // R4 output low two clocks after the input rises
        dur = 7'd3;
        align_line();
        begin
            exp_t e;
            e.width = 3 * L; e.tag = "R4 width";
            exp_q.push_back(e);
        end
        vfly = 1'b1;
        @(negedge clk);
        check(vblank_n == 1'b1, "R4 before sync", int'(vblank_n), 1);
        @(negedge clk);
        check(vblank_n == 1'b0, "R4 low after sync", int'(vblank_n), 0);
        @(negedge clk);
        vfly = 1'b0;
        wait_lines(5);

        // R1/R4 long flyback level dominates; its falling edge starts nothing
        dur = 7'd2; fire(5 * L, 5 * L, "R1 R4 long level");
        wait_lines(3);
        check(vblank_n == 1'b1, "R1 falling edge no pulse", int'(vblank_n), 1);
        wait_lines(2);

        // R3 retrigger during active pulse is locked out
        dur = 7'd5; fire(3, 5 * L, "R3 lockout");
        wait_lines(2);
        vfly = 1'b1; repeat (3) @(negedge clk); vfly = 1'b0;
        wait_lines(6);

        // R5 zero duration follows the flyback level only
        dur = 7'd0; fire(20, 20, "R5 dur=0"); wait_lines(4);

        // R6 change during a pulse applies to the next one
        dur = 7'd6; fire(3, 6 * L, "R6 in-flight unchanged");
        wait_lines(2); dur = 7'd2; wait_lines(6);
        fire(3, 2 * L, "R6 new value used"); wait_lines(4);

        // R7/R8 flyback loss and recovery
        dur = 7'd4; fire(3, 4 * L, "R2 dur=4");
        begin
            exp_t e;
            e.width = 4 * L; e.tag = "R7 free pulse";
            exp_q.push_back(e);
        end
        wait_lines(2040);
        check(no_video == 1'b0, "R7 not lost before 2048", int'(no_video), 0);
        wait_lines(14);
        check(no_video == 1'b1, "R7 lost after 2048", int'(no_video), 1);
        fire(3, 4 * L, "R8 recovery pulse");
        repeat (4) @(negedge clk);
        check(no_video == 1'b0, "R8 flag cleared", int'(no_video), 0);
        wait_lines(6);

        check(exp_q.size() == 0, "all expected pulses seen", exp_q.size(), 0);
        finish_run();
    end

endmodule